// File: doc/BRIEF.md
# Register-Controlled MDIO Management Master

This block runs clause-22 management transactions toward an Ethernet PHY on the MDC clock and MDIO data pins. Software sets it up through four 32-bit registers. A configuration word holds the MDC divisor and an interface enable. A control word holds the PHY address, the register address, the read/write selection and a start bit. Two more words hold the write data and the read data.

A transaction begins with one write to the control word, made while the block reports ready. The block then sends a complete 64-bit management frame and drops its ready flag until the last MDC cycle ends. For a read, the block releases the data pin from the turnaround onward and samples the PHY on each rising MDC edge. The 16-bit result appears in the read-data word at the moment ready returns high. Software completes each transaction by polling the ready bit.

The data pin is split into an output value, an output enable and an input, so the pad, its tri-state buffer and the pull-up sit outside the block.

Top module: `mdio_regmaster`

## Requirements
- R1: After reset the configuration word reads 0x0000_001D (divisor 29, enable 0), the ready flag (control bit 7) reads 1, and mdc and mdioOe are both low.
- R2: Word index busAddr[3:2] picks the register: 0 configuration (bit 6 enable, bits 5:0 divisor), 1 control, 2 write data (bits 15:0), 3 read data (bits 15:0). Control reads back PHY address in 28:24, register address in 20:16, read select in 15, write select in 14 and ready in 7. Bit 11 and all unlisted bits read 0.
- R3: During a frame mdc toggles every divisor+1 host clocks, giving a period of 2*(divisor+1) clocks. Between frames mdc stays low.
- R4: A frame starts only when a control write has bit 11 set, has bit 15 (read) or bit 14 (write) set, and arrives while ready is 1 and enable is 1. When bits 15 and 14 are both set, the frame is a read.
- R5: A write frame is 64 bits, each sent MSB first and held steady across the rising MDC edge: 32 ones, start 01, opcode 01, the 5-bit PHY address, the 5-bit register address, turnaround 10, then the 16 write-data bits. mdioOe is high for all 64 bits.
- R6: A read frame sends opcode 10. mdioOe drops for bits 46 to 63. The block samples mdioIn on the rising edge of bits 48 to 63, and the result reads back in the read-data word once ready is 1 again.
- R7: Ready is 0 from the start of a frame until the falling edge of its 64th MDC cycle, and mdc is high only while ready is 0.
- R8: A control write made while ready is 0 is ignored. It starts no frame and leaves the stored control fields unchanged.
- R9: While enable is 0, a start request starts no frame. Ready stays 1 and mdc stays low.
- R10: A read of a PHY that never drives the line, so that mdioIn stays high, returns 0xFFFF.
- R11: A control write with bit 11 set but with neither bit 15 nor bit 14 set starts no frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Register write strobe, one cycle per write |
| busAddr | input | 4 | Byte offset of the register; bits 3:2 select the word |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Read data of the addressed register (combinational) |
| mdc | output | 1 | Management clock toward the PHY |
| mdioOut | output | 1 | Value driven on the data pin |
| mdioOe | output | 1 | Drive enable for the data pin |
| mdioIn | input | 1 | Value seen on the data pin |

## Verification
The bench builds the block with its default parameters: a 6-bit divisor field and a reset divisor of 29. It then sets the divisor through the configuration word at run time. A divisor of 1 keeps each 64-bit frame to 256 clocks, which leaves room for many directed frames. The reset value of 29 is used once, to confirm the 60-clock MDC period. A behavioural PHY in the bench records every bit on rising MDC edges and answers read frames. It can also stay silent, which covers the absent-PHY case.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int DATA_BITS  = 16;
  localparam int ADDR_BITS  = 5;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  // first bit index at which a read releases the pin (turnaround)
  localparam int TA_FIRST   = 46;
  // first bit index carrying data
  localparam int DATA_FIRST = 48;
  localparam int LAST_BIT   = FRAME_BITS - 1;

  // control-word field positions
  localparam int PHY_LSB    = 24;
  localparam int REG_LSB    = 16;
  localparam int RD_BIT     = 15;
  localparam int WR_BIT     = 14;
  localparam int GO_BIT     = 11;
  localparam int READY_BIT  = 7;
  localparam int EN_BIT     = 6;

  typedef enum logic [1:0] {
    WORD_CFG   = 2'd0,
    WORD_CTRL  = 2'd1,
    WORD_WDATA = 2'd2,
    WORD_RDATA = 2'd3
  } word_e;

  typedef struct packed {
    logic load;      // capture frame into shifter
    logic shiftTx;   // advance to next outgoing bit
    logic sampleRx;  // capture one incoming data bit
    logic latchRd;   // move received word to read-data register
  } strobe_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             startIsRead,
  input  logic [DIV_W-1:0] cfgDiv,
  output strobe_t          strobe,
  output logic             ready,
  output logic             mdc,
  output logic             driveEn
);
  logic             busy;
  logic             isReadQ;
  logic             mdcQ;
  logic [DIV_W-1:0] divCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             tick;
  logic             riseNow;
  logic             fallNow;
  logic             lastBit;
  logic             launch;

  assign launch  = startReq && !busy;
  assign tick    = busy && (divCnt >= cfgDiv);
  assign riseNow = tick && !mdcQ;
  assign fallNow = tick && mdcQ;
  assign lastBit = (bitIdx == IDX_W'(LAST_BIT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      isReadQ <= 1'b0;
      mdcQ    <= 1'b0;
      divCnt  <= '0;
      bitIdx  <= '0;
    end else if (launch) begin
      busy    <= 1'b1;
      isReadQ <= startIsRead;
      mdcQ    <= 1'b0;
      divCnt  <= '0;
      bitIdx  <= '0;
    end else if (busy) begin
      if (tick) begin
        divCnt <= '0;
        mdcQ   <= ~mdcQ;
        if (fallNow) begin
          if (lastBit) busy <= 1'b0;
          else         bitIdx <= bitIdx + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.load     = launch;
    strobe.shiftTx  = fallNow && !lastBit;
    strobe.sampleRx = riseNow && isReadQ && (bitIdx >= IDX_W'(DATA_FIRST));
    strobe.latchRd  = fallNow && lastBit && isReadQ;
  end

  assign ready   = !busy;
  assign mdc     = mdcQ;
  assign driveEn = busy && !(isReadQ && (bitIdx >= IDX_W'(TA_FIRST)));
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DIV_W   = 6,
  parameter int DEF_DIV = 29
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  strobe_t           strobe,
  input  logic              ready,
  input  logic              driveEn,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              startReq,
  output logic              startIsRead,
  output logic [DIV_W-1:0]  cfgDiv,
  output logic              cfgEn
);
  logic [DIV_W-1:0]      divQ;
  logic                  enQ;
  logic [ADDR_BITS-1:0]  phyQ;
  logic [ADDR_BITS-1:0]  regQ;
  logic                  rdSelQ;
  logic                  wrSelQ;
  logic [DATA_BITS-1:0]  wrDataQ;
  logic [DATA_BITS-1:0]  rdDataQ;
  logic [FRAME_BITS-1:0] txShift;
  logic [DATA_BITS-1:0]  rxShift;
  logic [FRAME_BITS-1:0] frameWord;
  word_e                 wordSel;
  logic                  ctrlWr;
  logic                  wantRd;
  logic                  wantWr;

  assign wordSel = word_e'(busAddr[3:2]);
  assign ctrlWr  = busWe && (wordSel == WORD_CTRL) && ready;
  assign wantRd  = busWdata[RD_BIT];
  assign wantWr  = busWdata[WR_BIT];

  assign startReq    = ctrlWr && busWdata[GO_BIT] && (wantRd || wantWr) && enQ;
  assign startIsRead = wantRd;

  always_comb begin
    frameWord = {32'hFFFF_FFFF, 2'b01,
                 wantRd ? 2'b10 : 2'b01,
                 busWdata[PHY_LSB +: ADDR_BITS],
                 busWdata[REG_LSB +: ADDR_BITS],
                 wantRd ? 2'b11 : 2'b10,
                 wrDataQ};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ    <= DIV_W'(DEF_DIV);
      enQ     <= 1'b0;
      phyQ    <= '0;
      regQ    <= '0;
      rdSelQ  <= 1'b0;
      wrSelQ  <= 1'b0;
      wrDataQ <= '0;
    end else if (busWe) begin
      case (wordSel)
        WORD_CFG: begin
          divQ <= busWdata[DIV_W-1:0];
          enQ  <= busWdata[EN_BIT];
        end
        WORD_CTRL: begin
          if (ready) begin
            phyQ   <= busWdata[PHY_LSB +: ADDR_BITS];
            regQ   <= busWdata[REG_LSB +: ADDR_BITS];
            rdSelQ <= wantRd;
            wrSelQ <= wantWr;
          end
        end
        WORD_WDATA: wrDataQ <= busWdata[DATA_BITS-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1;
      rxShift <= '0;
      rdDataQ <= '0;
    end else begin
      if (strobe.load)
        txShift <= frameWord;
      else if (strobe.shiftTx)
        txShift <= {txShift[FRAME_BITS-2:0], 1'b1};
      if (strobe.sampleRx)
        rxShift <= {rxShift[DATA_BITS-2:0], mdioIn};
      if (strobe.latchRd)
        rdDataQ <= rxShift;
    end
  end

  always_comb begin
    busRdata = '0;
    case (wordSel)
      WORD_CFG: begin
        busRdata[DIV_W-1:0] = divQ;
        busRdata[EN_BIT]    = enQ;
      end
      WORD_CTRL: begin
        busRdata[PHY_LSB +: ADDR_BITS] = phyQ;
        busRdata[REG_LSB +: ADDR_BITS] = regQ;
        busRdata[RD_BIT]               = rdSelQ;
        busRdata[WR_BIT]               = wrSelQ;
        busRdata[READY_BIT]            = ready;
      end
      WORD_WDATA: busRdata[DATA_BITS-1:0] = wrDataQ;
      default:    busRdata[DATA_BITS-1:0] = rdDataQ;
    endcase
  end

  assign mdioOut = driveEn ? txShift[FRAME_BITS-1] : 1'b1;
  assign cfgDiv  = divQ;
  assign cfgEn   = enQ;
endmodule

// File: rtl/mdio_regmaster.sv
module mdio_regmaster
  import mdio_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DIV_W   = 6,
  parameter int DEF_DIV = 29
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  strobe_t          strobe;
  logic             ctrlReady;
  logic             driveEn;
  logic             startReq;
  logic             startIsRead;
  logic [DIV_W-1:0] cfgDiv;
  logic             cfgEn;

  mdio_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .startIsRead (startIsRead),
    .cfgDiv      (cfgDiv),
    .strobe      (strobe),
    .ready       (ctrlReady),
    .mdc         (mdc),
    .driveEn     (driveEn)
  );

  mdio_dp #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .busWe       (busWe),
    .busAddr     (busAddr),
    .busWdata    (busWdata),
    .busRdata    (busRdata),
    .strobe      (strobe),
    .ready       (ctrlReady),
    .driveEn     (driveEn),
    .mdioIn      (mdioIn),
    .mdioOut     (mdioOut),
    .startReq    (startReq),
    .startIsRead (startIsRead),
    .cfgDiv      (cfgDiv),
    .cfgEn       (cfgEn)
  );

  assign mdioOe = driveEn;
endmodule

// File: rtl/mdio_regmaster_chk.sv
module mdio_regmaster_chk #(
  parameter int DIV_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             mdc,
  input logic             mdioOe,
  input logic             ready,
  input logic             cfgEn,
  input logic [DIV_W-1:0] cfgDiv
);
  logic           mdcPrev;
  logic [DIV_W:0] gap;
  logic           seen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mdcPrev <= 1'b0;
      gap     <= '0;
      seen    <= 1'b0;
    end else begin
      mdcPrev <= mdc;
      if (ready) begin
        gap  <= '0;
        seen <= 1'b0;
      end else if (mdc != mdcPrev) begin
        gap  <= '0;
        seen <= 1'b1;
      end else begin
        gap <= gap + 1'b1;
      end
    end
  end

  // R3: spacing between successive MDC edges equals the divisor
  a_r3_mdc_spacing: assert property (@(posedge clk) disable iff (!rstN)
    ((mdc != mdcPrev) && seen) |-> (gap == {1'b0, cfgDiv}));

  // R7: MDC high only inside a frame
  a_r7_mdc_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    mdc |-> !ready);

  // R3, R7: idle interface keeps clock low and pin released
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (!mdc && !mdioOe));

  // R9: no frame begins while disabled
  a_r9_no_start_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !cfgEn) |=> ready);
endmodule

bind mdio_regmaster mdio_regmaster_chk #(.DIV_W(DIV_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .mdc    (mdc),
  .mdioOe (mdioOe),
  .ready  (ctrlReady),
  .cfgEn  (cfgEn),
  .cfgDiv (cfgDiv)
);

// File: tb/mdio_regmaster_tb.sv
`timescale 1ns/1ps
module mdio_regmaster_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int nChecks = 0;
  int nFails  = 0;

  // bench PHY model state
  logic [63:0] capOut;
  logic [63:0] capOe;
  int          phyBit = 0;
  logic        phyPresent = 1'b1;
  logic [15:0] phyData = 16'h0;
  time         tRise0, tRise1;

  always #10 clk = ~clk;

  mdio_regmaster u_dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always @(posedge mdc) begin
    if (phyBit < 64) begin
      capOut[63-phyBit] = mdioOut;
      capOe[63-phyBit]  = mdioOe;
    end
    if (phyBit == 0) tRise0 = $time;
    if (phyBit == 1) tRise1 = $time;
    phyBit = phyBit + 1;
  end

  always @(negedge mdc) begin
    mdioIn = 1'b1;
    if (phyPresent && capOut[29] && !capOut[28]) begin
      if (phyBit == 47) mdioIn = 1'b0;
      else if (phyBit >= 48 && phyBit <= 63) mdioIn = phyData[63-phyBit];
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic waitReady();
    logic [31:0] v;
    int n = 0;
    do begin
      busRead(4'h4, v);
      n++;
    end while (!v[7] && n < 20000);
  endtask

  function automatic logic [31:0] ctrlWord(input logic rd, input logic wr,
      input logic [4:0] phy, input logic [4:0] rg);
    return (32'(phy) << 24) | (32'(rg) << 16) | (32'(rd) << 15) |
           (32'(wr) << 14) | 32'h800;
  endfunction

  function automatic logic [63:0] expFrame(input logic rd, input logic [4:0] phy,
      input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg,
            rd ? 2'b11 : 2'b10, d};
  endfunction

  task automatic armPhy();
    phyBit = 0; capOut = '0; capOe = '0; mdioIn = 1'b1;
  endtask

  task automatic testReset();
    logic [31:0] v;
    busRead(4'h0, v); check("R1 cfg reset", 64'(v), 64'h1D);
    busRead(4'h4, v); check("R1 ready reset", 64'(v[7]), 64'h1);
    check("R1 mdc/oe reset", 64'({mdc, mdioOe}), 64'h0);
  endtask

  task automatic testRegs();
    logic [31:0] v;
    busWrite(4'h0, 32'hFFFF_FF41);
    busRead(4'h0, v); check("R2 cfg readback", 64'(v), 64'h41);
    busWrite(4'h8, 32'hABCD_1234);
    busRead(4'h8, v); check("R2 wdata readback", 64'(v), 64'h1234);
    busRead(4'hC, v); check("R2 rdata reset", 64'(v), 64'h0);
  endtask

  task automatic testWrite();
    logic [31:0] v;
    busWrite(4'h0, 32'h41);
    busWrite(4'h8, 32'hA5C3);
    armPhy();
    busWrite(4'h4, ctrlWord(1'b0, 1'b1, 5'd5, 5'd3));
    busRead(4'h4, v); check("R7 ready low in frame", 64'(v[7]), 64'h0);
    waitReady();
    check("R5 write frame bits", capOut, expFrame(1'b0, 5'd5, 5'd3, 16'hA5C3));
    check("R5 write oe", capOe, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R7 frame length", 64'(phyBit), 64'd64);
    busRead(4'h4, v);
    check("R2 ctrl readback", 64'(v), 64'(ctrlWord(1'b0, 1'b1, 5'd5, 5'd3) & ~32'h800 | 32'h80));
  endtask

  task automatic testRead(input logic present, input logic [15:0] d,
                          input logic [4:0] phy, input logic [4:0] rg, input string req);
    logic [31:0] v;
    logic [63:0] e;
    phyPresent = present; phyData = d;
    armPhy();
    busWrite(4'h4, ctrlWord(1'b1, 1'b0, phy, rg));
    waitReady();
    e = expFrame(1'b1, phy, rg, 16'h0);
    check({req, " read header"}, 64'(capOut[63:18]), 64'(e[63:18]));
    check({req, " read oe"}, capOe, 64'hFFFF_FFFF_FFFC_0000);
    busRead(4'hC, v);
    check({req, " read data"}, 64'(v), 64'(present ? d : 16'hFFFF));
    phyPresent = 1'b1;
  endtask

  task automatic testBothOps();
    armPhy();
    phyData = 16'h0F0F;
    busWrite(4'h4, ctrlWord(1'b1, 1'b1, 5'd2, 5'd4));
    waitReady();
    check("R4 both bits reads opcode", 64'(capOut[29:28]), 64'h2);
  endtask

  task automatic testPeriod();
    busWrite(4'h0, 32'h40 | 32'd29);
    armPhy();
    phyData = 16'h1357;
    busWrite(4'h4, ctrlWord(1'b1, 1'b0, 5'd1, 5'd1));
    waitReady();
    check("R3 mdc period div29", 64'(tRise1 - tRise0), 64'(60 * 20));
    busWrite(4'h0, 32'h40);
    armPhy();
    busWrite(4'h4, ctrlWord(1'b0, 1'b1, 5'd7, 5'd9));
    waitReady();
    check("R3 mdc period div0", 64'(tRise1 - tRise0), 64'(2 * 20));
    busWrite(4'h0, 32'h41);
  endtask

  task automatic testBusyIgnore();
    logic [31:0] v;
    busWrite(4'h8, 32'h5A5A);
    armPhy();
    busWrite(4'h4, ctrlWord(1'b0, 1'b1, 5'd5, 5'd3));
    repeat (20) @(negedge clk);
    busWrite(4'h4, ctrlWord(1'b1, 1'b0, 5'd9, 5'd9));
    waitReady();
    repeat (50) @(negedge clk);
    check("R8 frame unchanged", capOut, expFrame(1'b0, 5'd5, 5'd3, 16'h5A5A));
    check("R8 no second frame", 64'(phyBit), 64'd64);
    busRead(4'h4, v);
    check("R8 fields kept", 64'(v[28:14]), 64'((ctrlWord(1'b0, 1'b1, 5'd5, 5'd3) >> 14) & 32'h7FFF & ~32'h0));
  endtask

  task automatic testDisabled();
    logic [31:0] v;
    busWrite(4'h0, 32'h01);
    armPhy();
    busWrite(4'h4, ctrlWord(1'b1, 1'b0, 5'd3, 5'd3));
    repeat (100) @(negedge clk);
    busRead(4'h4, v);
    check("R9 ready stays", 64'(v[7]), 64'h1);
    check("R9 no mdc edges", 64'(phyBit), 64'd0);
    busWrite(4'h0, 32'h41);
  endtask

  task automatic testNoOp();
    logic [31:0] v;
    armPhy();
    busWrite(4'h4, 32'h0300_0800);
    repeat (100) @(negedge clk);
    busRead(4'h4, v);
    check("R11 ready stays", 64'(v[7]), 64'h1);
    check("R11 no frame", 64'(phyBit), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegs();
    testWrite();
    testRead(1'b1, 16'hBEEF, 5'd17, 5'd2, "R6");
    testRead(1'b1, 16'h8001, 5'd31, 5'd31, "R6b");
    testRead(1'b0, 16'h1234, 5'd0, 5'd1, "R10");
    testBothOps();
    testPeriod();
    testBusyIgnore();
    testDisabled();
    testNoOp();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule